// File: doc/BRIEF.md
# Flash in-system programming command sequencer

This block gives software a small register window through which it can read, program and erase words of an on-chip flash array. To run an operation, software writes the target byte address, the data word (for a program) and a 6-bit command code. It then sets the start bit in the trigger register. The block decides whether the operation is allowed, based on the update-enable bits, the region the CPU currently boots from and the address. It then either issues one request on the flash port or fails the operation at once and raises a sticky fail flag.

The flash side is a valid/ready request channel plus a response pulse. The controller raises `fl_req_valid` and keeps the opcode, address and write data unchanged until it sees `fl_req_ready` high on the same clock edge. Back-pressure from the array therefore only stretches the operation. After the handshake the controller always accepts `fl_rsp_valid`, which must be a single-cycle pulse that arrives some cycles later. The register port is plain: a write strobe, a 5-bit byte offset and a combinational read-data output. The lock/unlock key sequence lives elsewhere and reaches this block only as the `unlock_i` level.

The region map is set by parameters:
- main application region: `[0, MAIN_BYTES)`
- loader region: `[LDR_BASE, LDR_BASE+LDR_BYTES)`
- configuration words: `[CFG_BASE, CFG_BASE+CFG_BYTES)`

With the defaults these are 128 KB at 0, 4 KB at 0x0010_0000 and 8 bytes at 0x0030_0000.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset every register reads 0. The only exception is the boot-select bit (control bit1), which takes the value of `boot_ldr_i` during reset.
- R2: Register offsets are: control 0x00, address 0x04, data 0x08, command 0x0C, trigger 0x10, data-flash base 0x14, access-time 0x18. Any other offset reads 0. In the control register, bit0 is enable, bit1 is boot select (1 = running from loader), bit3 is main-region update enable, bit4 is config update enable, bit5 is loader update enable and bit6 is the fail flag. The command register holds 6 bits in [5:0]. The access-time register holds low-frequency mode at bit4 and mid-frequency mode at bit6. All unlisted bits read 0.
- R3: Control bits 0, 1, 3, 4, 5 and access-time bits 4 and 6 change on a write only while `unlock_i` is 1. Without unlock, such writes leave them unchanged.
- R4: A write of 1 to trigger bit0 starts an operation only when the enable bit is 1 and no operation is running. The trigger bit then reads 1 until the operation ends and 0 afterwards. With enable at 0 the write is ignored.
- R5: Command 0x00 (read) issues a flash request with opcode 0. When the response arrives, the returned word is loaded into the data register.
- R6: Command 0x21 issues opcode 1 (program) carrying the data register. Command 0x22 issues opcode 2 (page erase). The request address is the address register in both cases.
- R7: While `fl_req_valid` is 1 and `fl_req_ready` is 0, the request stays valid and its opcode, address and data stay unchanged.
- R8: A program or erase in the main region fails while boot select is 0 and main update enable is 0.
- R9: A program or erase in the loader region fails while boot select is 1 and loader update enable is 0.
- R10: A program or erase of the configuration words fails while config update enable is 0. Reads of them are allowed.
- R11: An operation fails in any of three cases: its address has bits [1:0] not equal to 00, its address lies outside all three regions, or its command code is not one of the three listed. A failing operation makes no flash request. It sets the fail flag and ends so that the trigger bit reads 1 for exactly one cycle.
- R12: The fail flag is cleared by writing 1 to control bit6, whatever the state of `unlock_i`. Writing 0 there leaves it unchanged. A set in the same cycle as a clear wins.
- R13: With `fixed_df_i` at 1 the data-flash base reads MAIN_BYTES-4096 (0x0001_F000 by default). Otherwise it reads `cfg_df_base_i`.
- R14: Writes to the address, data and command registers are ignored while an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| unlock_i | input | 1 | Write-protection unlock level |
| boot_ldr_i | input | 1 | Boot-select value loaded at reset |
| fixed_df_i | input | 1 | Fixed 4 KB data-flash mode |
| cfg_df_base_i | input | 32 | Configured data-flash base |
| fl_req_valid | output | 1 | Flash request valid |
| fl_req_ready | input | 1 | Flash request accepted |
| fl_req_op | output | 2 | 0 read, 1 program, 2 page erase |
| fl_req_addr | output | 32 | Flash byte address |
| fl_req_wdata | output | 32 | Program data |
| fl_rsp_valid | input | 1 | Single-cycle completion pulse |
| fl_rsp_rdata | input | 32 | Read data, valid with `fl_rsp_valid` |
| low_freq_o | output | 1 | Low-frequency access mode |
| mid_freq_o | output | 1 | Mid-frequency access mode |

## Verification
The assertions check the following on every cycle:
- the request is held stable under back-pressure;
- a request appears only during a running operation and only with a word-aligned address;
- the fail flag rises only as an operation ends without a request;
- locked control writes leave the protected bits alone;
- an enable-off trigger starts nothing;
- the operand registers stay frozen while busy.

Only the bench scenarios can show that each permission and range rule maps to the correct pass or fail outcome, that read data lands in the data register, and that register read-back, the unlock gate on the access-time bits and the base-register selection follow the map.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [REG_AW-1:0] OFS_ADDR = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DATA = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CMD  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_TRG  = 5'h10;
  localparam logic [REG_AW-1:0] OFS_DFB  = 5'h14;
  localparam logic [REG_AW-1:0] OFS_ATC  = 5'h18;

  localparam logic [5:0] CMD_READ  = 6'h00;
  localparam logic [5:0] CMD_PROG  = 6'h21;
  localparam logic [5:0] CMD_ERASE = 6'h22;

  typedef enum logic [1:0] {
    FOP_READ  = 2'd0,
    FOP_PROG  = 2'd1,
    FOP_ERASE = 2'd2
  } flash_op_e;

  // protected control bits, MSB first: loader upd, cfg upd, main upd, boot sel, enable
  typedef struct packed {
    logic ld_upd;
    logic cfg_upd;
    logic main_upd;
    logic boot_ldr;
    logic isp_en;
  } ctrl_t;
endpackage

// File: rtl/isp_regfile.sv
module isp_regfile
  import flash_isp_pkg::*;
#(
  parameter logic [31:0] DF_FIXED_BASE = 32'h0001_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              unlock_i,
  input  logic              boot_ldr_i,
  input  logic              fixed_df_i,
  input  logic [31:0]       cfg_df_base_i,
  input  logic              busy,
  input  logic              fail_set,
  input  logic              data_load,
  input  logic [31:0]       data_load_val,
  output ctrl_t             ctrl,
  output logic              fail_flag,
  output logic [31:0]       isp_addr,
  output logic [31:0]       isp_data,
  output logic [5:0]        isp_cmd,
  output logic              go,
  output logic              low_freq_o,
  output logic              mid_freq_o
);
  logic wr_ctrl, wr_addr, wr_data, wr_cmd, wr_atc, fail_clr;
  logic [31:0] df_base;

  assign wr_ctrl  = bus_wr_en && (bus_addr == OFS_CTRL);
  assign wr_addr  = bus_wr_en && (bus_addr == OFS_ADDR) && !busy;
  assign wr_data  = bus_wr_en && (bus_addr == OFS_DATA) && !busy;
  assign wr_cmd   = bus_wr_en && (bus_addr == OFS_CMD)  && !busy;
  assign wr_atc   = bus_wr_en && (bus_addr == OFS_ATC)  && unlock_i;
  assign fail_clr = wr_ctrl && bus_wdata[6];
  assign go       = bus_wr_en && (bus_addr == OFS_TRG) && bus_wdata[0]
                    && ctrl.isp_en && !busy;
  assign df_base  = fixed_df_i ? DF_FIXED_BASE : cfg_df_base_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl          <= '0;
      ctrl.boot_ldr <= boot_ldr_i;
      fail_flag     <= 1'b0;
      isp_addr      <= '0;
      isp_data      <= '0;
      isp_cmd       <= '0;
      low_freq_o    <= 1'b0;
      mid_freq_o    <= 1'b0;
    end else begin
      if (wr_ctrl && unlock_i) begin
        ctrl.isp_en   <= bus_wdata[0];
        ctrl.boot_ldr <= bus_wdata[1];
        ctrl.main_upd <= bus_wdata[3];
        ctrl.cfg_upd  <= bus_wdata[4];
        ctrl.ld_upd   <= bus_wdata[5];
      end
      if (fail_set)      fail_flag <= 1'b1;
      else if (fail_clr) fail_flag <= 1'b0;
      if (wr_addr) isp_addr <= bus_wdata;
      if (data_load)    isp_data <= data_load_val;
      else if (wr_data) isp_data <= bus_wdata;
      if (wr_cmd) isp_cmd <= bus_wdata[5:0];
      if (wr_atc) begin
        low_freq_o <= bus_wdata[4];
        mid_freq_o <= bus_wdata[6];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = {25'b0, fail_flag, ctrl.ld_upd, ctrl.cfg_upd,
                             ctrl.main_upd, 1'b0, ctrl.boot_ldr, ctrl.isp_en};
      OFS_ADDR: bus_rdata = isp_addr;
      OFS_DATA: bus_rdata = isp_data;
      OFS_CMD:  bus_rdata = {26'b0, isp_cmd};
      OFS_TRG:  bus_rdata = {31'b0, busy};
      OFS_DFB:  bus_rdata = df_base;
      OFS_ATC:  bus_rdata = {25'b0, mid_freq_o, 1'b0, low_freq_o, 4'b0};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/isp_legality.sv
module isp_legality
  import flash_isp_pkg::*;
#(
  parameter logic [31:0] MAIN_BYTES = 32'h0002_0000,
  parameter logic [31:0] LDR_BASE   = 32'h0010_0000,
  parameter logic [31:0] LDR_BYTES  = 32'h0000_1000,
  parameter logic [31:0] CFG_BASE   = 32'h0030_0000,
  parameter logic [31:0] CFG_BYTES  = 32'h0000_0008
) (
  input  logic [31:0] addr,
  input  logic [5:0]  cmd,
  input  ctrl_t       ctrl,
  output flash_op_e   op,
  output logic        deny
);
  localparam logic [31:0] LDR_END = LDR_BASE + LDR_BYTES;
  localparam logic [31:0] CFG_END = CFG_BASE + CFG_BYTES;

  logic in_main, in_ldr, in_cfg, known, is_write, bad_addr;
  logic deny_main, deny_ldr, deny_cfg;

  assign in_main = addr < MAIN_BYTES;
  assign in_ldr  = (addr >= LDR_BASE) && (addr < LDR_END);
  assign in_cfg  = (addr >= CFG_BASE) && (addr < CFG_END);

  always_comb begin
    known = 1'b1;
    op    = FOP_READ;
    case (cmd)
      CMD_READ:  op = FOP_READ;
      CMD_PROG:  op = FOP_PROG;
      CMD_ERASE: op = FOP_ERASE;
      default:   known = 1'b0;
    endcase
  end

  assign is_write  = known && (op != FOP_READ);
  assign bad_addr  = (addr[1:0] != 2'b00) || !(in_main || in_ldr || in_cfg);
  assign deny_main = is_write && in_main && !ctrl.boot_ldr && !ctrl.main_upd;
  assign deny_ldr  = is_write && in_ldr  &&  ctrl.boot_ldr && !ctrl.ld_upd;
  assign deny_cfg  = is_write && in_cfg  && !ctrl.cfg_upd;
  assign deny      = !known || bad_addr || deny_main || deny_ldr || deny_cfg;
endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
  import flash_isp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      deny,
  input  flash_op_e op,
  input  logic      fl_req_ready,
  input  logic      fl_rsp_valid,
  output logic      busy,
  output logic      fail_set,
  output logic      fl_req_valid,
  output logic      data_load
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_REQ, S_WAIT} state_e;
  state_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (go) nxt = S_EVAL;
      S_EVAL: nxt = deny ? S_IDLE : S_REQ;
      S_REQ:  if (fl_req_ready) nxt = S_WAIT;
      S_WAIT: if (fl_rsp_valid) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign busy         = (state != S_IDLE);
  assign fail_set     = (state == S_EVAL) && deny;
  assign fl_req_valid = (state == S_REQ);
  assign data_load    = (state == S_WAIT) && fl_rsp_valid && (op == FOP_READ);
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter logic [31:0] MAIN_BYTES     = 32'h0002_0000,
  parameter logic [31:0] LDR_BASE       = 32'h0010_0000,
  parameter logic [31:0] LDR_BYTES      = 32'h0000_1000,
  parameter logic [31:0] CFG_BASE       = 32'h0030_0000,
  parameter logic [31:0] CFG_BYTES      = 32'h0000_0008,
  parameter logic [31:0] DF_FIXED_BYTES = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        unlock_i,
  input  logic        boot_ldr_i,
  input  logic        fixed_df_i,
  input  logic [31:0] cfg_df_base_i,
  output logic        fl_req_valid,
  input  logic        fl_req_ready,
  output logic [1:0]  fl_req_op,
  output logic [31:0] fl_req_addr,
  output logic [31:0] fl_req_wdata,
  input  logic        fl_rsp_valid,
  input  logic [31:0] fl_rsp_rdata,
  output logic        low_freq_o,
  output logic        mid_freq_o
);
  localparam logic [31:0] DF_FIXED_BASE = MAIN_BYTES - DF_FIXED_BYTES;

  ctrl_t       ctrl_w;
  logic        fail_w, busy_w, go_w, deny_w, fail_set_w, load_w;
  logic [31:0] addr_w, data_w;
  logic [5:0]  cmd_w;
  flash_op_e   op_w;

  isp_regfile #(.DF_FIXED_BASE(DF_FIXED_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .unlock_i(unlock_i), .boot_ldr_i(boot_ldr_i),
    .fixed_df_i(fixed_df_i), .cfg_df_base_i(cfg_df_base_i),
    .busy(busy_w), .fail_set(fail_set_w),
    .data_load(load_w), .data_load_val(fl_rsp_rdata),
    .ctrl(ctrl_w), .fail_flag(fail_w),
    .isp_addr(addr_w), .isp_data(data_w), .isp_cmd(cmd_w), .go(go_w),
    .low_freq_o(low_freq_o), .mid_freq_o(mid_freq_o)
  );

  isp_legality #(
    .MAIN_BYTES(MAIN_BYTES), .LDR_BASE(LDR_BASE), .LDR_BYTES(LDR_BYTES),
    .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES)
  ) u_legal (
    .addr(addr_w), .cmd(cmd_w), .ctrl(ctrl_w), .op(op_w), .deny(deny_w)
  );

  isp_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .deny(deny_w), .op(op_w),
    .fl_req_ready(fl_req_ready), .fl_rsp_valid(fl_rsp_valid),
    .busy(busy_w), .fail_set(fail_set_w), .fl_req_valid(fl_req_valid),
    .data_load(load_w)
  );

  assign fl_req_op    = op_w;
  assign fl_req_addr  = addr_w;
  assign fl_req_wdata = data_w;
endmodule

// File: rtl/flash_isp_props.sv
module flash_isp_props (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic [4:0]  bus_addr,
  input logic        unlock_i,
  input logic        fl_req_valid,
  input logic        fl_req_ready,
  input logic [1:0]  fl_req_op,
  input logic [31:0] fl_req_addr,
  input logic [31:0] fl_req_wdata,
  input logic        busy,
  input logic        fail_flag,
  input logic [4:0]  prot_bits,
  input logic [31:0] isp_addr
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_ready |=> fl_req_valid && $stable(fl_req_op)
      && $stable(fl_req_addr) && $stable(fl_req_wdata));

  assert_req_in_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> busy);

  assert_req_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> fl_req_addr[1:0] == 2'b00);

  // covers R8, R9, R10, R11: a failure ends the operation without a request
  assert_fail_ends_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> !busy && !fl_req_valid);

  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_addr == 5'h00 && !unlock_i |=> $stable(prot_bits));

  assert_trigger_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_addr == 5'h10 && !prot_bits[0] && !busy |=> !busy);

  assert_addr_frozen_R14: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr_en && bus_addr == 5'h04 |=> $stable(isp_addr));
endmodule

bind flash_isp_ctrl flash_isp_props u_props (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .unlock_i(unlock_i), .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready),
  .fl_req_op(fl_req_op), .fl_req_addr(fl_req_addr), .fl_req_wdata(fl_req_wdata),
  .busy(busy_w), .fail_flag(fail_w), .prot_bits(ctrl_w), .isp_addr(addr_w)
);

// File: tb/flash_isp_ctrl_test.sv
module flash_isp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        unlock_i = 1'b0;
  logic        boot_ldr_i = 1'b1;
  logic        fixed_df_i = 1'b0;
  logic [31:0] cfg_df_base_i = 32'h0000_C000;
  logic        fl_req_valid, fl_req_ready = 1'b0;
  logic [1:0]  fl_req_op;
  logic [31:0] fl_req_addr, fl_req_wdata;
  logic        fl_rsp_valid = 1'b0;
  logic [31:0] fl_rsp_rdata = '0;
  logic        low_freq_o, mid_freq_o;

  int checks = 0, errors = 0;
  int req_cnt = 0;
  logic [1:0]  last_op;
  logic [31:0] last_addr, last_wdata;
  bit stall = 0, done = 0;

  always #10 clk = ~clk;

  flash_isp_ctrl uut (.*);

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) fl_req_ready = !stall && ($urandom % 3 != 0);

  always @(posedge clk) begin
    fl_rsp_valid <= 1'b0;
    if (fl_req_valid && fl_req_ready) begin
      req_cnt      <= req_cnt + 1;
      last_op      <= fl_req_op;
      last_addr    <= fl_req_addr;
      last_wdata   <= fl_req_wdata;
      fl_rsp_valid <= 1'b1;
      fl_rsp_rdata <= model_rd(fl_req_addr);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic run_op(output int cyc);
    logic [31:0] t;
    wr(5'h10, 32'h1);
    cyc = 0;
    for (int i = 0; i < 60; i++) begin
      rd(5'h10, t);
      if (t[0] == 1'b0) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic bit exp_fail(input logic [31:0] a, input logic [5:0] c,
                                  input bit bs, input bit mu, input bit cu, input bit lu);
    bit known = (c == 6'h00) || (c == 6'h21) || (c == 6'h22);
    bit wrop  = (c == 6'h21) || (c == 6'h22);
    bit im = a < 32'h2_0000;
    bit il = a >= 32'h10_0000 && a < 32'h10_1000;
    bit ic = a >= 32'h30_0000 && a < 32'h30_0008;
    if (!known || a[1:0] != 0 || !(im || il || ic)) return 1;
    if (wrop && im && !bs && !mu) return 1;
    if (wrop && il && bs && !lu) return 1;
    if (wrop && ic && !cu) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, d;
    logic [5:0]  c;
    int cyc, n0;
    bit bs, mu, cu, lu, ef;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, v); chk("R1 ctrl", v, 32'h2);
    rd(5'h04, v); chk("R1 addr", v, 0);
    rd(5'h0C, v); chk("R1 cmd", v, 0);
    rd(5'h10, v); chk("R1 trigger", v, 0);
    rd(5'h18, v); chk("R1 atc", v, 0);
    // R13 base selection
    rd(5'h14, v); chk("R13 cfg base", v, 32'h0000_C000);
    fixed_df_i = 1; rd(5'h14, v); chk("R13 fixed base", v, 32'h0001_F000);
    // R3 locked writes
    wr(5'h00, 32'h3B); rd(5'h00, v); chk("R3 locked ctrl", v, 32'h2);
    wr(5'h18, 32'h50); rd(5'h18, v); chk("R3 locked atc", v, 0);
    unlock_i = 1;
    wr(5'h18, 32'hFF); rd(5'h18, v); chk("R2 R3 atc bits", v, 32'h50);
    chk("R3 freq pins", {30'b0, mid_freq_o, low_freq_o}, 32'h3);
    // R2 reserved bits
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R2 ctrl mask", v, 32'h3B);
    wr(5'h0C, 32'hFFFF); rd(5'h0C, v); chk("R2 cmd mask", v, 32'h3F);
    rd(5'h1C, v); chk("R2 unmapped", v, 0);
    // R4 enable off: trigger ignored
    wr(5'h00, 32'h0); n0 = req_cnt;
    wr(5'h04, 32'h100); wr(5'h0C, 32'h0);
    wr(5'h10, 32'h1); rd(5'h10, v); chk("R4 off trigger", v, 0);
    chk("R4 no request", req_cnt, n0);
    // R11 one-cycle failure, misaligned
    wr(5'h00, 32'h3B); wr(5'h04, 32'h102);
    run_op(cyc); chk("R11 one cycle", cyc, 1);
    chk("R11 no request", req_cnt, n0);
    rd(5'h00, v); chk("R11 fail flag", v[6], 1);
    // R12 clear without unlock, and write-0 keeps
    unlock_i = 0;
    wr(5'h00, 32'h0); rd(5'h00, v); chk("R12 write0 keeps", v[6], 1);
    wr(5'h00, 32'h40); rd(5'h00, v); chk("R12 w1c", v, 32'h3B);
    unlock_i = 1;
    // R14 frozen operands while stalled
    stall = 1;
    wr(5'h04, 32'h200); wr(5'h08, 32'hCAFE_0001); wr(5'h0C, 32'h21);
    wr(5'h10, 32'h1);
    wr(5'h04, 32'h300); wr(5'h08, 32'h1); wr(5'h0C, 32'h22);
    rd(5'h04, v); chk("R14 addr frozen", v, 32'h200);
    rd(5'h08, v); chk("R14 data frozen", v, 32'hCAFE_0001);
    rd(5'h0C, v); chk("R14 cmd frozen", v, 32'h21);
    rd(5'h10, v); chk("R4 busy reads 1", v, 1);
    stall = 0;
    for (int i = 0; i < 40; i++) begin rd(5'h10, v); if (!v[0]) break; @(negedge clk); end
    chk("R6 program op", last_op, 1);
    chk("R6 program data", last_wdata, 32'hCAFE_0001);

    // random mix
    for (int it = 0; it < 300; it++) begin
      bs = $urandom; mu = $urandom; cu = $urandom; lu = $urandom;
      case ($urandom % 6)
        0: a = ($urandom % 32'h2_0000) & ~32'h3;
        1: a = 32'h10_0000 + (($urandom % 32'h1000) & ~32'h3);
        2: a = 32'h30_0000 + ($urandom % 2) * 4;
        3: a = 32'h2_0000 + ($urandom % 32'h1000) * 4;
        4: a = (($urandom % 32'h2_0000) & ~32'h3) | (1 + $urandom % 3);
        default: a = 32'h20_0000 + ($urandom % 64) * 4;
      endcase
      case ($urandom % 4)
        0: c = 6'h00;
        1: c = 6'h21;
        2: c = 6'h22;
        default: c = $urandom;
      endcase
      d = $urandom;
      ef = exp_fail(a, c, bs, mu, cu, lu);
      wr(5'h00, {25'b0, 1'b1, lu, cu, mu, 1'b0, bs, 1'b1});
      wr(5'h04, a); wr(5'h08, d); wr(5'h0C, {26'b0, c});
      n0 = req_cnt;
      run_op(cyc);
      rd(5'h00, v);
      chk(c == 6'h21 || c == 6'h22 ? "R8 R9 R10 R11 fail flag" : "R11 fail flag", v[6], ef);
      chk("R11 request count", req_cnt - n0, ef ? 0 : 1);
      if (ef) chk("R11 fail length", cyc, 1);
      else begin
        chk("R5 R6 request addr", last_addr, a);
        chk("R5 R6 opcode", last_op, c == 6'h00 ? 0 : (c == 6'h21 ? 1 : 2));
        if (c == 6'h21) chk("R6 wdata", last_wdata, d);
        rd(5'h08, v);
        chk("R5 data register", v, c == 6'h00 ? model_rd(a) : d);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule